// File: doc/BRIEF.md
# Fixed-Off-Time Current Chopper Controller

This block is the digital control for one constant-current H-bridge channel. It divides the master clock by a programmable ratio to form an internal tick. It drives the load until a synchronous current-limit comparator input asserts. It then holds the bridge in short-brake slow decay for a fixed number of ticks, after which it starts driving again. When the current reference steps down, a programmable burst of fast decay can be inserted. Fast decay reverses the bridge so that the coil current returns to the supply, and slow decay and the full off period follow it. When the reference steps up, the block returns to drive at once.

The controller's phase is mapped onto four gate-enable outputs, one per transistor of the two half-bridges. Every change of phase passes through a dead interval with all four gates off. An enable input parks the channel: it turns all gates off and re-arms the controller so that drive starts as soon as enable returns. Of two reference events in the same cycle, the step-down wins. Either reference event takes precedence over the comparator.

Top module: `chopper_ctrl`

## Requirements
- R1: The internal tick occurs once every n master-clock cycles for a ratio code n of 1 to 31, and a code of 0 acts as 1. While enable is low the divider is held, so after enable rises the first tick falls on the n-th rising edge.
- R2: The off period is 2, 4, 6 or 8 ticks for off codes 0, 1, 2 and 3. Ticks are counted on the edges after the one that enters the off phase. Drive resumes on the tick after the last counted one.
- R3: In the drive phase, the comparator input asserting ends drive on that edge and enters slow decay. The comparator has no effect during slow or fast decay.
- R4: Slow decay shows as gate outputs {hs_a,ls_a,hs_b,ls_b} = 0101, which is both low sides on.
- R5: Drive shows as 1001 (hs_a with ls_b). Fast decay shows as 0110 (hs_b with ls_a).
- R6: A reference step-down with fast code F greater than 0 gives F ticks of fast decay. Slow decay then follows with the full off period. With F = 0, a step-down goes straight to slow decay.
- R7: A reference step-up during slow decay returns to drive on that edge, without waiting for the off period to end.
- R8: The gate outputs follow the controller phase one cycle later. Each change between two phases is preceded by DEAD_CYC cycles (default 1) with all outputs at 0000.
- R9: Enable low forces the outputs to 0000 from the next edge and returns the controller to drive-ready. The first edge with enable high then shows drive.
- R10: While the synchronous active-low reset is low, the outputs are 0000. The first edge after release with enable high shows drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable; low parks the bridge and re-arms the controller |
| div_ratio | input | 5 | Master-clock divide ratio for the tick (0 acts as 1) |
| off_code | input | 2 | Off period select: 2, 4, 6 or 8 ticks |
| fast_code | input | 2 | Fast-decay length in ticks after a reference step-down |
| limit_hit | input | 1 | Synchronous current-limit comparator output |
| ref_down | input | 1 | One-cycle pulse: the reference stepped down |
| ref_up | input | 1 | One-cycle pulse: the reference stepped up |
| hs_a | output | 1 | Gate enable, high side of leg A |
| ls_a | output | 1 | Gate enable, low side of leg A |
| hs_b | output | 1 | Gate enable, high side of leg B |
| ls_b | output | 1 | Gate enable, low side of leg B |

## Verification
A comparator or reference event sampled at edge m changes the phase at m, the gates go dark at m+1, and the new phase appears at m+1+DEAD_CYC. When the return to drive is decided at edge e, drive therefore shows at e+2 with the default dead time. After re-enabling, each episode starts the divider from a known phase, so the bench knows that tick edges fall where the edge index k satisfies k mod n = n-1. From this it computes the cycle in which drive returns, and how many cycles show slow decay, fast decay and dead time. All inputs change at falling edges and all outputs are sampled at falling edges, which gives every result a fixed cycle index to compare against.

// File: rtl/chop_pkg.sv
// Shared types for the chopper controller.
// The bridge phase is carried between the sequencer and the gate mapper.
package chop_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // all gates off (dead time or parked)
        PH_DRIVE = 2'd1,   // current builds in the coil
        PH_SLOW  = 2'd2,   // short brake through both low sides
        PH_FAST  = 2'd3    // reversed bridge, current returns to supply
    } phase_t;
endpackage

// File: rtl/chop_tick_div.sv
// Tick divider: pulses tick once every ratio clock cycles.
// Assumes ratio is quasi-static; a code of 0 is treated as 1.
// While run is low the count is held at zero.
module chop_tick_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;

    assign eff  = (ratio == '0) ? DIV_W'(1) : ratio;
    assign tick = run && (cnt_q >= eff - DIV_W'(1));

    // Cycle counter, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff != DIV_W'(1)) |=> (!tick || ratio != $past(ratio))); // R1
endmodule

// File: rtl/chop_fsm.sv
// Chopping sequencer: drive until the limit input, then slow decay for a
// fixed number of ticks. A reference step-down can insert a fast-decay
// burst first. Step-down has priority over step-up, and both have
// priority over the comparator. Assumes the fast code fits the counter.
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_W  = 2,
    parameter int FAST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              limit,
    input  logic              step_down,
    input  logic              step_up,
    input  logic [OFF_W-1:0]  off_code,
    input  logic [FAST_W-1:0] fast_code,
    output phase_t            phase
);
    localparam int OFF_MAX = 2 * (1 << OFF_W);
    localparam int CNT_W   = $clog2(OFF_MAX + 1);

    phase_t           st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] off_lim;
    logic [CNT_W-1:0] fast_lim;

    assign off_lim  = CNT_W'((int'(off_code) + 1) * 2);
    assign fast_lim = CNT_W'(fast_code);
    assign phase    = st_q;

    // Phase register and tick counter for the off and fast intervals.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            st_q  <= PH_DRIVE;
            cnt_q <= '0;
        end else if (step_down) begin
            st_q  <= (fast_code != '0) ? PH_FAST : PH_SLOW;
            cnt_q <= '0;
        end else if (step_up) begin
            st_q  <= PH_DRIVE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                PH_DRIVE: if (limit) begin
                    st_q  <= PH_SLOW;
                    cnt_q <= '0;
                end
                PH_SLOW: if (tick) begin
                    if (cnt_q == off_lim) begin
                        st_q  <= PH_DRIVE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_FAST: if (tick) begin
                    if (cnt_q + CNT_W'(1) == fast_lim) begin
                        st_q  <= PH_SLOW;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_q  <= PH_DRIVE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    AST_LIMIT_ENDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q == PH_DRIVE && limit && !step_down && !step_up) |=> st_q == PH_SLOW); // R3
    AST_SLOW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q == PH_SLOW && !tick && !step_down && !step_up) |=> st_q == PH_SLOW); // R2
    AST_FAST_NOT_TO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q == PH_FAST && !step_up) |=> st_q != PH_DRIVE); // R6
endmodule

// File: rtl/chop_gate_map.sv
// Gate mapper: follows the requested phase one cycle late. It inserts
// DEAD cycles of all-off between two phases, then decodes the applied
// phase onto the four gate enables. Assumes DEAD >= 1.
module chop_gate_map
    import chop_pkg::*;
#(
    parameter int DEAD = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  phase_t req,
    output logic   hs_a,
    output logic   ls_a,
    output logic   hs_b,
    output logic   ls_b
);
    localparam int DW = (DEAD > 1) ? $clog2(DEAD) : 1;

    phase_t        applied_q;
    logic [DW-1:0] dcnt_q;

    // Applied phase with the dead-time countdown in front of each change.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            applied_q <= PH_IDLE;
            dcnt_q    <= '0;
        end else if (dcnt_q != '0) begin
            dcnt_q <= dcnt_q - DW'(1);
        end else if (applied_q != req) begin
            if (applied_q == PH_IDLE) begin
                applied_q <= req;
            end else begin
                applied_q <= PH_IDLE;
                dcnt_q    <= DW'(DEAD - 1);
            end
        end
    end

    // Decode of the applied phase onto the gate enables.
    always_comb begin
        {hs_a, ls_a, hs_b, ls_b} = 4'b0000;
        case (applied_q)
            PH_DRIVE: begin hs_a = 1'b1; ls_b = 1'b1; end
            PH_SLOW:  begin ls_a = 1'b1; ls_b = 1'b1; end
            PH_FAST:  begin hs_b = 1'b1; ls_a = 1'b1; end
            default:  {hs_a, ls_a, hs_b, ls_b} = 4'b0000;
        endcase
    end

    AST_DEAD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_q != PH_IDLE && $past(applied_q) != PH_IDLE) |-> applied_q == $past(applied_q)); // R8
    AST_PARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> {hs_a, ls_a, hs_b, ls_b} == 4'b0000); // R9
endmodule

// File: rtl/chopper_ctrl.sv
// Top of the fixed-off-time chopper controller for one H-bridge channel.
// Assumes limit_hit, ref_down and ref_up are synchronous to clk.
module chopper_ctrl
    import chop_pkg::*;
#(
    parameter int DIV_W    = 5,
    parameter int OFF_W    = 2,
    parameter int FAST_W   = 2,
    parameter int DEAD_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [OFF_W-1:0]  off_code,
    input  logic [FAST_W-1:0] fast_code,
    input  logic              limit_hit,
    input  logic              ref_down,
    input  logic              ref_up,
    output logic              hs_a,
    output logic              ls_a,
    output logic              hs_b,
    output logic              ls_b
);
    logic   tick;
    phase_t phase;

    chop_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(enable), .ratio(div_ratio), .tick(tick)
    );

    chop_fsm #(.OFF_W(OFF_W), .FAST_W(FAST_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick),
        .limit(limit_hit), .step_down(ref_down), .step_up(ref_up),
        .off_code(off_code), .fast_code(fast_code), .phase(phase)
    );

    chop_gate_map #(.DEAD(DEAD_CYC)) u_map (
        .clk(clk), .rst_n(rst_n), .run(enable), .req(phase),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );
endmodule

// File: tb/chopper_ctrl_test.sv
module chopper_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n, enable, limit_hit, ref_down, ref_up;
    logic [4:0] div_ratio;
    logic [1:0] off_code, fast_code;
    logic       hs_a, ls_a, hs_b, ls_b;
    int         nchecks = 0;
    int         nerr = 0;

    localparam logic [3:0] G_OFF = 4'b0000, G_DRV = 4'b1001,
                           G_SLW = 4'b0101, G_FST = 4'b0110;

    typedef struct packed {
        logic [4:0] dv;
        logic [1:0] oc;
        int         drive;
        int         slow;
    } vec_t;

    // Limit at edge 3; expected drive-return cycle and slow-decay cycles.
    localparam vec_t VECS [0:5] = '{
        '{5'd1,  2'd0, 8,   2},
        '{5'd1,  2'd3, 14,  8},
        '{5'd3,  2'd1, 19,  13},
        '{5'd0,  2'd0, 8,   2},
        '{5'd31, 2'd3, 280, 274},
        '{5'd5,  2'd2, 36,  30}
    };

    chopper_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_ratio(div_ratio),
        .off_code(off_code), .fast_code(fast_code), .limit_hit(limit_hit),
        .ref_down(ref_down), .ref_up(ref_up),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] gates();
        return {hs_a, ls_a, hs_b, ls_b};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int ev, input logic v);
        case (ev)
            1: limit_hit = v;
            2: ref_down  = v;
            3: ref_up    = v;
            default: ;
        endcase
    endtask

    // One episode from a fresh enable; the first event is sampled at edge 3.
    task automatic episode(input logic [4:0] dv, input logic [1:0] oc, input logic [1:0] fc,
                           input int ev1, input int ev2k, input int ev2,
                           input int exp_drive, input int exp_slow, input int exp_fast,
                           input int exp_dead, input string tag);
        int drive_k = -1;
        int n_slow = 0;
        int n_fast = 0;
        int n_dead = 0;
        @(negedge clk);
        enable = 1'b0; limit_hit = 1'b0; ref_down = 1'b0; ref_up = 1'b0;
        @(negedge clk);
        div_ratio = dv; off_code = oc; fast_code = fc; enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk({tag, " R9 R5 drive before event"}, int'(gates()), int'(G_DRV));
        apply(ev1, 1'b1);
        @(negedge clk);
        apply(ev1, 1'b0);
        for (int k = 4; k <= 400; k++) begin
            @(negedge clk);
            if (k == 4) chk({tag, " R8 dead after event"}, int'(gates()), int'(G_OFF));
            if (gates() == G_SLW) n_slow++;
            if (gates() == G_FST) n_fast++;
            if (gates() == G_OFF) n_dead++;
            if (gates() == G_DRV) begin
                drive_k = k;
                break;
            end
            if (ev2 != 0 && k == ev2k - 1) apply(ev2, 1'b1);
            if (ev2 != 0 && k == ev2k) apply(ev2, 1'b0);
        end
        apply(ev2, 1'b0);
        chk({tag, " drive return cycle"}, drive_k, exp_drive);
        chk({tag, " R4 slow cycles"}, n_slow, exp_slow);
        chk({tag, " R5 fast cycles"}, n_fast, exp_fast);
        chk({tag, " R8 dead cycles"}, n_dead, exp_dead);
    endtask

    initial begin
        #(200000 * 4);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; limit_hit = 1'b0; ref_down = 1'b0; ref_up = 1'b0;
        div_ratio = 5'd1; off_code = 2'd0; fast_code = 2'd0;
        repeat (3) @(negedge clk);
        chk("R10 outputs off in reset", int'(gates()), int'(G_OFF));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 drive after release", int'(gates()), int'(G_DRV));
        enable = 1'b0;
        @(negedge clk);
        chk("R9 enable low forces off", int'(gates()), int'(G_OFF));

        // Vector table: divide ratio and off period sweep (R1 R2 R3).
        for (int i = 0; i < 6; i++)
            episode(VECS[i].dv, VECS[i].oc, 2'd0, 1, 0, 0,
                    VECS[i].drive, VECS[i].slow, 0, 2, "R1 R2 R3 vector");

        // Comparator during slow decay is ignored.
        episode(5'd1, 2'd3, 2'd0, 1, 6, 1, 14, 8, 0, 2, "R3 limit in off");
        // Fast decay bursts after a step-down.
        episode(5'd1, 2'd0, 2'd2, 2, 0, 0, 10, 2, 1, 3, "R6 fast two");
        episode(5'd1, 2'd0, 2'd3, 2, 0, 0, 11, 2, 2, 3, "R6 fast three");
        episode(5'd1, 2'd0, 2'd0, 2, 0, 0, 8, 2, 0, 2, "R6 fast zero");
        // Step-up cuts the off period short.
        episode(5'd1, 2'd3, 2'd0, 1, 6, 3, 8, 2, 0, 2, "R7 step up");

        // Re-arm: parking during slow decay returns straight to drive.
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        div_ratio = 5'd1; off_code = 2'd3; fast_code = 2'd0; enable = 1'b1;
        repeat (3) @(negedge clk);
        limit_hit = 1'b1;
        @(negedge clk);
        limit_hit = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 slow decay pattern", int'(gates()), int'(G_SLW));
        enable = 1'b0;
        @(negedge clk);
        chk("R9 park during slow", int'(gates()), int'(G_OFF));
        enable = 1'b1;
        @(negedge clk);
        chk("R9 drive-ready after park", int'(gates()), int'(G_DRV));

        $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end
endmodule